// File: doc/BRIEF.md
# Multicycle Shared-ALU Datapath

This block is the 32-bit datapath of a load/store processor that spends several clock cycles on each instruction. There is only one arithmetic unit. It is used again in different cycles: to step the program counter, to add a shifted offset for a branch target, to form a base-plus-offset data address, and to do register-to-register arithmetic. Two input selectors in front of the arithmetic unit choose its operands for each of these uses. One word-addressed memory holds both instructions and data. An address selector points that memory either at the program counter or at the registered result of the arithmetic unit.

Staging registers carry values from one cycle to the next. These are the instruction register, the two operand latches, the result latch and the load-data latch. The instruction register and the program counter load only when told to. The other staging registers take a new value on every edge. Every steering and write-enable signal is a primary input, so an external sequencer (or a bench) plays the controller role. The block returns the opcode field and the zero flag of the arithmetic unit to that sequencer. A write port for preloading the memory lets a program and its data be placed before execution.

Top module: `mcyc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0 and the instruction register becomes 0, so `opcode` reads 0.
- R2: `pc` changes only at an edge where `pc_wr` is high. It then takes the live result of the arithmetic unit when `npc_sel` is 0, and the value held in the result latch when `npc_sel` is 1.
- R3: The instruction register loads the memory read data only at an edge where `ir_wr` is high, and otherwise keeps its value. `opcode` shows its bits 31:26.
- R4: `opa_sel` = 0 gives the arithmetic unit `pc` as its first operand. `opa_sel` = 1 gives it the operand latch that holds register[IR 25:21].
- R5: `opb_sel` picks the second operand: 0 = operand latch holding register[IR 20:16], 1 = constant 4, 2 = IR 15:0 sign-extended, 3 = IR 15:0 sign-extended and shifted left by 2.
- R6: `alu_op` codes are 000 AND, 001 OR, 010 ADD, 110 SUB (first minus second), 111 set-less-than. Set-less-than gives 1 when the first operand is smaller as a signed number and 0 otherwise. Any other code gives 0.
- R7: `zero` is high exactly when the live result of the arithmetic unit is 0. A SUB of the two operand latches therefore tests them for equality.
- R8: The memory word index is bits [AW+1:2] of the selected address. `addr_sel` = 0 selects `pc` and 1 selects the result latch. A store writes the second operand latch at an edge where `mem_wr` is high.
- R9: `mem_dout` shows the addressed word, with no clock delay, while `mem_rd` is high, and reads 0 while `mem_rd` is low.
- R10: The operand latches, the result latch and the load-data latch have no enable. Each captures its source at every rising edge: register-file reads, arithmetic result and `mem_dout`. `alu_out` shows the result latch.
- R11: `dst_sel` = 1 writes register IR 15:11 and 0 writes register IR 20:16. `wb_sel` = 1 writes the load-data latch and 0 writes the result latch. The write happens at an edge where `reg_wr` is high.
- R12: Register 0 always reads as 0, and writes to it have no effect.
- R13: At an edge where `ld_en` is high, memory word `ld_idx` takes `ld_data`. This preload wins over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory preload write strobe |
| ld_idx | input | AW | Preload word index |
| ld_data | input | DW | Preload write data |
| pc_wr | input | 1 | Program counter load enable |
| ir_wr | input | 1 | Instruction register load enable |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory store enable |
| addr_sel | input | 1 | Memory address select: 0 pc, 1 result latch |
| opa_sel | input | 1 | First operand select |
| opb_sel | input | 2 | Second operand select |
| alu_op | input | 3 | Arithmetic unit operation code |
| npc_sel | input | 1 | Next-pc source select |
| dst_sel | input | 1 | Write register field select |
| wb_sel | input | 1 | Register write data select |
| reg_wr | input | 1 | Register file write enable |
| opcode | output | 6 | Instruction register bits 31:26 |
| zero | output | 1 | Arithmetic result is zero |
| pc | output | DW | Program counter |
| alu_out | output | DW | Result latch |
| mem_dout | output | DW | Memory read data |

## Verification
The bench acts as the sequencer and drives the control steps of fetch, decode, register arithmetic, load, store and equal-branch instructions. A reference model tracks the registers, memory and program counter. Register operands come first from corner values (0, all ones, the most negative and the most positive number) and then from seeded random values. This separates signed from unsigned set-less-than and checks the zero flag on equal and unequal pairs. Directed patterns separate the remaining cases: loads with a nonzero and a negative offset, a load whose rd field names a live register (it shows which field is written), writes aimed at register 0, a store racing a preload, a memory read with the instruction-register load held off, and branches taken forward, taken backward and not taken.

// File: rtl/mdp_pkg.sv
`timescale 1ns/1ps
package mdp_pkg;
  // arithmetic unit operation codes
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  // second operand selector codes
  localparam logic [1:0] OPB_REG  = 2'd0;
  localparam logic [1:0] OPB_FOUR = 2'd1;
  localparam logic [1:0] OPB_IMM  = 2'd2;
  localparam logic [1:0] OPB_IMM4 = 2'd3;

  // fixed instruction field layout
  localparam int F_OP_LSB  = 26;
  localparam int F_RS_LSB  = 21;
  localparam int F_RT_LSB  = 16;
  localparam int F_RD_LSB  = 11;
  localparam int F_REG_W   = 5;
  localparam int F_OP_W    = 6;
  localparam int F_IMM_W   = 16;
endpackage

// File: rtl/mdp_alu.sv
`timescale 1ns/1ps
module mdp_alu
  import mdp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);
  logic [DW-1:0] sum;
  logic [DW-1:0] diff;
  logic          lt;

  assign sum  = a + b;
  assign diff = a - b;
  assign lt   = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_ADD:  y = sum;
      OP_SUB:  y = diff;
      OP_SLT:  y = {{(DW-1){1'b0}}, lt};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mdp_regfile.sv
`timescale 1ns/1ps
module mdp_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [DW-1:0]  wd,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  output logic [DW-1:0]  rd1,
  output logic [DW-1:0]  rd2
);
  logic [DW-1:0] regs [NREG];

  // register 0 is hard-wired; its storage is never written
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mdp_mem.sv
`timescale 1ns/1ps
module mdp_mem #(
  parameter int DW    = 32,
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] arr [WORDS];

  // single write port, one read port
  always_ff @(posedge clk) begin
    if (we) arr[widx] <= wdata;
  end

  assign rdata = re ? arr[ridx] : '0;
endmodule

// File: rtl/mcyc_datapath.sv
`timescale 1ns/1ps
module mcyc_datapath
  import mdp_pkg::*;
#(
  parameter int DW        = 32,
  parameter int MEM_WORDS = 256,
  localparam int AW       = $clog2(MEM_WORDS),
  localparam int NREG     = 1 << F_REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          pc_wr,
  input  logic          ir_wr,
  input  logic          mem_rd,
  input  logic          mem_wr,
  input  logic          addr_sel,
  input  logic          opa_sel,
  input  logic [1:0]    opb_sel,
  input  logic [2:0]    alu_op,
  input  logic          npc_sel,
  input  logic          dst_sel,
  input  logic          wb_sel,
  input  logic          reg_wr,
  output logic [5:0]    opcode,
  output logic          zero,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] alu_out,
  output logic [DW-1:0] mem_dout
);
  // staging state
  logic [DW-1:0] pc_q;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] a_q;
  logic [DW-1:0] b_q;
  logic [DW-1:0] alu_out_q;
  logic [DW-1:0] mdr_q;

  // instruction fields
  logic [F_REG_W-1:0] rs_f, rt_f, rd_f;
  logic [DW-1:0]      imm_sx, imm_sx4;

  assign rs_f    = ir_q[F_RS_LSB +: F_REG_W];
  assign rt_f    = ir_q[F_RT_LSB +: F_REG_W];
  assign rd_f    = ir_q[F_RD_LSB +: F_REG_W];
  assign imm_sx  = {{(DW-F_IMM_W){ir_q[F_IMM_W-1]}}, ir_q[F_IMM_W-1:0]};
  assign imm_sx4 = {imm_sx[DW-3:0], 2'b00};

  // operand steering
  logic [DW-1:0] opa, opb, alu_res;

  assign opa = opa_sel ? a_q : pc_q;

  always_comb begin
    unique case (opb_sel)
      OPB_REG:  opb = b_q;
      OPB_FOUR: opb = DW'(4);
      OPB_IMM:  opb = imm_sx;
      default:  opb = imm_sx4;
    endcase
  end

  mdp_alu #(.DW(DW)) u_alu (
    .op   (alu_op),
    .a    (opa),
    .b    (opb),
    .y    (alu_res),
    .zero (zero)
  );

  // register file
  logic [F_REG_W-1:0] wr_reg;
  logic [DW-1:0]      wr_data, rf_rd1, rf_rd2;

  assign wr_reg  = dst_sel ? rd_f : rt_f;
  assign wr_data = wb_sel ? mdr_q : alu_out_q;

  mdp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk (clk),
    .we  (reg_wr),
    .wa  (wr_reg),
    .wd  (wr_data),
    .ra1 (rs_f),
    .ra2 (rt_f),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2)
  );

  // unified memory, preload shares the single write port
  logic [DW-1:0] maddr;
  logic [AW-1:0] midx, widx;
  logic          mwe;
  logic [DW-1:0] mwdata;
  logic          unused_maddr_bits;

  assign maddr  = addr_sel ? alu_out_q : pc_q;
  assign midx   = maddr[AW+1:2];
  assign unused_maddr_bits = ^{maddr[DW-1:AW+2], maddr[1:0]};
  assign mwe    = ld_en | mem_wr;
  assign widx   = ld_en ? ld_idx : midx;
  assign mwdata = ld_en ? ld_data : b_q;

  mdp_mem #(.DW(DW), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mwe),
    .widx  (widx),
    .wdata (mwdata),
    .re    (mem_rd),
    .ridx  (midx),
    .rdata (mem_dout)
  );

  // program counter and instruction register
  logic [DW-1:0] npc;
  assign npc = npc_sel ? alu_out_q : alu_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_wr) pc_q <= npc;
      if (ir_wr) ir_q <= mem_dout;
    end
  end

  // enable-free stage latches
  always_ff @(posedge clk) begin
    a_q       <= rf_rd1;
    b_q       <= rf_rd2;
    alu_out_q <= alu_res;
    mdr_q     <= mem_dout;
  end

  assign pc      = pc_q;
  assign alu_out = alu_out_q;
  assign opcode  = ir_q[F_OP_LSB +: F_OP_W];
endmodule

// File: rtl/mcyc_datapath_chk.sv
`timescale 1ns/1ps
module mcyc_datapath_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          pc_wr,
  input logic          ir_wr,
  input logic          npc_sel,
  input logic          opa_sel,
  input logic [1:0]    opb_sel,
  input logic [2:0]    alu_op,
  input logic [DW-1:0] pc,
  input logic [5:0]    opcode,
  input logic          zero,
  input logic [DW-1:0] ir_q,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] b_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && opcode == '0));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && !npc_sel && !opa_sel && opb_sel == 2'd1 && alu_op == 3'b010)
      |=> (pc == $past(pc) + DW'(4)));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_wr |=> $stable(pc));

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable(opcode));

  // R7
  eq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (opa_sel && opb_sel == 2'd0 && alu_op == 3'b110) |-> (zero == (a_q == b_q)));

  // R12
  r0_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_q[25:21] == 5'd0) |=> (a_q == '0));
endmodule

bind mcyc_datapath mcyc_datapath_chk #(.DW(DW)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .pc_wr   (pc_wr),
  .ir_wr   (ir_wr),
  .npc_sel (npc_sel),
  .opa_sel (opa_sel),
  .opb_sel (opb_sel),
  .alu_op  (alu_op),
  .pc      (pc),
  .opcode  (opcode),
  .zero    (zero),
  .ir_q    (ir_q),
  .a_q     (a_q),
  .b_q     (b_q)
);

// File: tb/test_mcyc_datapath.sv
`timescale 1ns/1ps
module test_mcyc_datapath;
  localparam int DW = 32;
  localparam int WORDS = 256;
  localparam int AW = 8;
  localparam logic [2:0] A_AND = 3'b000, A_OR = 3'b001, A_ADD = 3'b010,
                         A_SUB = 3'b110, A_SLT = 3'b111;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic rst, ld_en, pc_wr, ir_wr, mem_rd, mem_wr, addr_sel, opa_sel;
  logic npc_sel, dst_sel, wb_sel, reg_wr;
  logic [AW-1:0] ld_idx;
  logic [DW-1:0] ld_data;
  logic [1:0] opb_sel;
  logic [2:0] alu_op;
  logic [5:0] opcode;
  logic zero;
  logic [DW-1:0] pc, alu_out, mem_dout;

  mcyc_datapath #(.DW(DW), .MEM_WORDS(WORDS)) i_mcyc_datapath (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .pc_wr(pc_wr), .ir_wr(ir_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .addr_sel(addr_sel), .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_op(alu_op),
    .npc_sel(npc_sel), .dst_sel(dst_sel), .wb_sel(wb_sel), .reg_wr(reg_wr),
    .opcode(opcode), .zero(zero), .pc(pc), .alu_out(alu_out), .mem_dout(mem_dout)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] rm [32];
  logic [DW-1:0] mm [WORDS];
  logic [DW-1:0] pc_m, ir_m, a_m, b_m, ao_m, mdr_m;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] sx(input logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic [DW-1:0] alu_f(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      A_AND: return a & b;
      A_OR:  return a | b;
      A_ADD: return a + b;
      A_SUB: return a - b;
      A_SLT: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] enc_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
    return {6'd0, rs, rt, rd, 11'd0};
  endfunction

  function automatic logic [DW-1:0] enc_i(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic ctl0();
    ld_en = 0; ld_idx = '0; ld_data = '0;
    pc_wr = 0; ir_wr = 0; mem_rd = 0; mem_wr = 0; addr_sel = 0; opa_sel = 0;
    opb_sel = 2'd0; alu_op = A_AND; npc_sel = 0; dst_sel = 0; wb_sel = 0; reg_wr = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [AW-1:0] idx, input logic [DW-1:0] d);
    ctl0(); ld_en = 1; ld_idx = idx; ld_data = d;
    step();
    ctl0();
    mm[idx] = d;
  endtask

  task automatic fetch();
    logic [DW-1:0] w;
    ctl0(); pc_wr = 1; ir_wr = 1; mem_rd = 1; opb_sel = 2'd1; alu_op = A_ADD;
    w = mm[pc_m[9:2]];
    step();
    ir_m = w; pc_m = pc_m + 4;
    chk("R2 pc step", pc, pc_m);
    chk("R3 opcode load", {26'd0, opcode}, {26'd0, ir_m[31:26]});
  endtask

  task automatic decode();
    ctl0(); opb_sel = 2'd3; alu_op = A_ADD;
    step();
    a_m = rm[ir_m[25:21]]; b_m = rm[ir_m[20:16]];
    ao_m = pc_m + {sx(ir_m[15:0]), 2'b00}[DW-1:0];
    chk("R4 R5 shifted target", alu_out, ao_m);
  endtask

  task automatic rexec(input logic [2:0] op);
    logic [DW-1:0] r;
    ctl0(); opa_sel = 1; opb_sel = 2'd0; alu_op = op;
    r = alu_f(op, a_m, b_m);
    #1;
    chk("R7 zero flag", {31'd0, zero}, {31'd0, (r == '0)});
    step();
    ao_m = r;
    // R12: operands read from register 0 are 0 in the model
    chk("R6 R10 register op", alu_out, ao_m);
  endtask

  task automatic rwb();
    ctl0(); dst_sel = 1; reg_wr = 1;
    step();
    // R11 rd written; R12 writes to register 0 dropped
    if (ir_m[15:11] != 5'd0) rm[ir_m[15:11]] = ao_m;
  endtask

  task automatic maddr();
    ctl0(); opa_sel = 1; opb_sel = 2'd2; alu_op = A_ADD;
    step();
    ao_m = a_m + sx(ir_m[15:0]);
    chk("R4 R5 effective address", alu_out, ao_m);
  endtask

  task automatic swmem(input bit clash, input logic [DW-1:0] cd);
    ctl0(); mem_wr = 1; addr_sel = 1;
    if (clash) begin ld_en = 1; ld_idx = ao_m[9:2]; ld_data = cd; end
    #1;
    chk("R9 gated read", mem_dout, '0);
    step();
    // R13 preload wins over store
    mm[ao_m[9:2]] = clash ? cd : b_m;
  endtask

  task automatic lwmem();
    ctl0(); mem_rd = 1; addr_sel = 1;
    #1;
    mdr_m = mm[ao_m[9:2]];
    chk("R8 R13 data read", mem_dout, mdr_m);
    step();
  endtask

  task automatic lwwb();
    ctl0(); wb_sel = 1; reg_wr = 1;
    step();
    // R11 rt written with load data
    if (ir_m[20:16] != 5'd0) rm[ir_m[20:16]] = mdr_m;
  endtask

  task automatic beqdone();
    bit tk;
    ctl0(); opa_sel = 1; opb_sel = 2'd0; alu_op = A_SUB; npc_sel = 1;
    tk = (a_m == b_m);
    #1;
    chk("R7 equality", {31'd0, zero}, {31'd0, tk});
    pc_wr = tk;
    step();
    if (tk) pc_m = ao_m;
    chk("R2 branch pc", pc, pc_m);
  endtask

  task automatic do_r(input logic [2:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
    put(pc_m[9:2], enc_r(rs, rt, rd));
    fetch(); decode(); rexec(op); rwb();
  endtask

  task automatic do_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
    put(pc_m[9:2], enc_i(6'h23, rs, rt, imm));
    fetch(); decode(); maddr(); lwmem(); lwwb();
  endtask

  task automatic do_sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                       input bit clash, input logic [DW-1:0] cd);
    put(pc_m[9:2], enc_i(6'h2B, rs, rt, imm));
    fetch(); decode(); maddr(); swmem(clash, cd);
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off);
    put(pc_m[9:2], enc_i(6'h04, rs, rt, off));
    fetch(); decode(); beqdone();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [2:0] ops [5];
    seed = $urandom(32'd2024);
    ops[0] = A_AND; ops[1] = A_OR; ops[2] = A_ADD; ops[3] = A_SUB; ops[4] = A_SLT;
    for (int i = 0; i < 32; i++) rm[i] = '0;
    pc_m = '0;
    ctl0();
    rst = 1;
    repeat (3) step();
    chk("R1 reset pc", pc, '0);
    chk("R1 reset ir", {26'd0, opcode}, '0);
    rst = 0;
    step();
    chk("R1 pc after reset", pc, '0);

    // data area
    put(8'd200, 32'h0000_0000);
    put(8'd201, 32'hFFFF_FFFF);
    put(8'd202, 32'h8000_0000);
    put(8'd203, 32'h7FFF_FFFF);
    for (int k = 4; k < 8; k++) put(AW'(200 + k), $urandom);
    put(8'd208, 32'h5A5A_1234);
    put(8'd210, 32'd840);
    put(8'd240, 32'h0BAD_F00D);

    for (int k = 1; k <= 8; k++) do_lw(5'(k), 5'd0, 16'(800 + 4 * (k - 1)));
    do_lw(5'd9, 5'd0, 16'd840);
    for (int k = 1; k <= 9; k++) do_r(A_ADD, 5'(k), 5'd0, 5'd16);

    // R12: loads and results aimed at register 0
    do_lw(5'd0, 5'd0, 16'd804);
    do_r(A_OR, 5'd0, 5'd0, 5'd17);
    do_r(A_ADD, 5'd2, 5'd2, 5'd0);
    do_r(A_ADD, 5'd0, 5'd0, 5'd18);

    // R8: store through base register, load back
    do_sw(5'd5, 5'd9, 16'd16, 1'b0, '0);
    do_lw(5'd11, 5'd0, 16'd856);
    do_r(A_ADD, 5'd11, 5'd0, 5'd19);

    // R5: negative offset
    do_lw(5'd13, 5'd9, 16'hFFF8);
    do_r(A_ADD, 5'd13, 5'd0, 5'd20);

    // R11: load with rd field naming register 3 writes rt only
    do_lw(5'd14, 5'd0, 16'h1BC0);
    do_r(A_ADD, 5'd3, 5'd0, 5'd21);
    do_r(A_ADD, 5'd14, 5'd0, 5'd22);

    // R13: preload in the same cycle as a store
    do_sw(5'd6, 5'd9, 16'd24, 1'b1, 32'hC0FF_EE11);
    do_lw(5'd23, 5'd9, 16'd24);
    do_r(A_ADD, 5'd23, 5'd0, 5'd24);

    // R3: memory read at pc with IR load off keeps opcode; R2 pc holds
    put(pc_m[9:2], enc_i(6'h23, 5'd1, 5'd2, 16'd0));
    ctl0(); mem_rd = 1; addr_sel = 0;
    step();
    chk("R3 ir held", {26'd0, opcode}, 32'd0);
    chk("R2 pc held", pc, pc_m);

    // branches
    do_beq(5'd2, 5'd2, 16'd3);
    do_beq(5'd1, 5'd2, 16'd2);
    do_beq(5'd3, 5'd4, 16'hFFFF);
    do_beq(5'd5, 5'd5, 16'hFFFE);

    // R6: signed compare corners
    do_r(A_SLT, 5'd3, 5'd4, 5'd25);
    do_r(A_SLT, 5'd4, 5'd3, 5'd26);
    do_r(A_SLT, 5'd2, 5'd1, 5'd27);
    do_r(A_SUB, 5'd4, 5'd4, 5'd28);

    // random register operations
    for (int n = 0; n < 24; n++) begin
      logic [4:0] rs, rt, rd;
      rs = 5'($urandom_range(8, 1));
      rt = (n % 6 == 0) ? rs : 5'($urandom_range(8, 1));
      rd = 5'($urandom_range(8, 1));
      do_r(ops[$urandom_range(4, 0)], rs, rt, rd);
    end

    // R1: reset in mid-run
    ctl0(); rst = 1;
    step();
    chk("R1 late reset pc", pc, '0);
    chk("R1 late reset ir", {26'd0, opcode}, '0);
    rst = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule